// File: doc/BRIEF.md
# Serial Clock Divider with Programmable High Phase

This block derives the serial clock of a serial-peripheral master from the system clock. Two counters run in series. A prescaler divides the system clock by P. A cycle counter then counts P-wide ticks through one output period of N ticks. A separate high count H sets how many of those ticks the output stays high, so the duty cycle and the total division ratio are programmed independently. A bypass setting passes the system clock straight through when the divided rates are too slow.

Software works out the divider values and writes each field as the value it wants minus one. The block takes a new configuration only while it is idle. A shift engine uses the two single-cycle edge pulses to know when to launch and when to capture data. It does not need to watch the clock level.

Top module: `sclk_gen`

## Requirements
- R1: During reset, and while `en` is low, `sclk`, `sclk_rise` and `sclk_fall` are all low.
- R2: When `en` is sampled high while the block is idle, a new period starts with its high phase: in the next cycle `sclk` is 1 and `sclk_rise` is 1.
- R3: In divide mode the period is P*N system clocks. P = `cfg_pre_m1`+1 (1 to 8192). N = min(`cfg_cyc_m1`, `cfg_low_m1`)+1 (1 to 64).
- R4: With N of 2 or more, `sclk` is high for the first min(H, N)*P system clocks of each period, where H = `cfg_high_m1`+1. When H >= N the output stays high for as long as the block runs.
- R5: With N = 1, `sclk` is high for the first ceil(P/2) system clocks of every P-cycle period. With P = 1 as well, the output stays high.
- R6: In divide mode, `sclk_rise` is 1 for exactly one cycle, in the cycle where `sclk` first reads 1 after reading 0. `sclk_fall` behaves the same way for the change from 1 to 0. The two pulses are never 1 together.
- R7: With `cfg_bypass`=1 at start, `sclk` follows the system clock while the block runs, and `sclk_rise` and `sclk_fall` are both held at 1. The divider fields have no effect.
- R8: The configuration is captured in the start cycle. Changes to the configuration inputs while the block runs have no effect until the next start.
- R9: When `en` is sampled low, `sclk` is 0 in the next cycle. `sclk_fall` pulses in that cycle if `sclk` was high in divide mode.
- R10: A low count smaller than the cycle length shortens the period to the low count: the smaller of the two fields sets N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request; high runs the clock, low idles it |
| cfg_bypass | input | 1 | Pass the system clock straight through |
| cfg_pre_m1 | input | PRE_W | Prescale factor minus one |
| cfg_cyc_m1 | input | CYC_W | Cycle length minus one |
| cfg_high_m1 | input | CYC_W | High-phase tick count minus one |
| cfg_low_m1 | input | CYC_W | Low count minus one; normally equal to the cycle length field |
| sclk | output | 1 | Divided serial clock |
| sclk_rise | output | 1 | One-cycle pulse when sclk goes high |
| sclk_fall | output | 1 | One-cycle pulse when sclk goes low |

## Verification
A wrong prescaler or cycle count shows first as an edge that comes one or more system clocks early or late. That error appears within the first period after start, at the latest P*N clocks later. A wrong high-phase comparison moves the falling edge inside the same first period. A register that misses the configuration latch shows up at the first tick boundary after a mid-run change.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    localparam int DEF_PRE_W = 13;
    localparam int DEF_CYC_W = 6;

    typedef enum logic [1:0] {
        DRV_IDLE   = 2'd0,
        DRV_DIV    = 2'd1,
        DRV_HALF   = 2'd2,
        DRV_BYPASS = 2'd3
    } drive_mode_e;

    // How the output is driven in the coming cycle
    function automatic drive_mode_e pick_mode(input logic run_req,
                                              input logic bypass,
                                              input logic single_tick);
        if (!run_req)         return DRV_IDLE;
        else if (bypass)      return DRV_BYPASS;
        else if (single_tick) return DRV_HALF;
        else                  return DRV_DIV;
    endfunction

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt_d,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    always_comb begin
        wrap = advance && (cnt_q == limit);
        if (!advance)  cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sclk_cycle.sv
module sclk_cycle #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt_d
);
    logic [W-1:0] cnt_q;

    always_comb begin
        if (!advance)             cnt_d = '0;
        else if (!step)           cnt_d = cnt_q;
        else if (cnt_q >= limit)  cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sclk_wave.sv
module sclk_wave
    import sclk_gen_pkg::*;
#(
    parameter int PRE_W = 13,
    parameter int CYC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  drive_mode_e       mode,
    input  logic [PRE_W-1:0]  pcnt_d,
    input  logic [CYC_W-1:0]  ccnt_d,
    input  logic [PRE_W-1:0]  pre_m1,
    input  logic [CYC_W-1:0]  high_m1,
    output logic              wave_q,
    output logic              rise_q,
    output logic              fall_q
);
    localparam int HW = PRE_W + 1;

    logic [HW-1:0] half_lim;
    logic          level_d;

    // ceil(P/2) with P = pre_m1 + 1
    assign half_lim = ({1'b0, pre_m1} + HW'(2)) >> 1;

    always_comb begin
        unique case (mode)
            DRV_DIV:  level_d = (ccnt_d <= high_m1);
            DRV_HALF: level_d = ({1'b0, pcnt_d} < half_lim);
            default:  level_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            wave_q <= level_d;
            rise_q <= level_d && !wave_q;
            fall_q <= !level_d && wave_q;
        end
    end
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_gen_pkg::*;
#(
    parameter int PRE_W = DEF_PRE_W,
    parameter int CYC_W = DEF_CYC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cfg_bypass,
    input  logic [PRE_W-1:0] cfg_pre_m1,
    input  logic [CYC_W-1:0] cfg_cyc_m1,
    input  logic [CYC_W-1:0] cfg_high_m1,
    input  logic [CYC_W-1:0] cfg_low_m1,
    output logic             sclk,
    output logic             sclk_rise,
    output logic             sclk_fall
);
    logic             run_q;
    logic             byp_q;
    logic [PRE_W-1:0] pre_q;
    logic [CYC_W-1:0] cyc_q, high_q, low_q;

    logic             byp_eff;
    logic [PRE_W-1:0] pre_eff;
    logic [CYC_W-1:0] cyc_eff, high_eff, low_eff, lim_eff;
    logic             advance, wrap, byp_run;
    logic [PRE_W-1:0] pcnt_d;
    logic [CYC_W-1:0] ccnt_d;
    logic             wave_q, rise_q, fall_q;
    drive_mode_e      mode;

    // Configuration is captured while idle and frozen while running
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            byp_q  <= 1'b0;
            pre_q  <= '0;
            cyc_q  <= '0;
            high_q <= '0;
            low_q  <= '0;
        end else begin
            run_q <= en;
            if (!run_q) begin
                byp_q  <= cfg_bypass;
                pre_q  <= cfg_pre_m1;
                cyc_q  <= cfg_cyc_m1;
                high_q <= cfg_high_m1;
                low_q  <= cfg_low_m1;
            end
        end
    end

    assign byp_eff  = run_q ? byp_q  : cfg_bypass;
    assign pre_eff  = run_q ? pre_q  : cfg_pre_m1;
    assign cyc_eff  = run_q ? cyc_q  : cfg_cyc_m1;
    assign high_eff = run_q ? high_q : cfg_high_m1;
    assign low_eff  = run_q ? low_q  : cfg_low_m1;
    assign lim_eff  = (low_eff < cyc_eff) ? low_eff : cyc_eff;

    assign advance = en && run_q && !byp_eff;
    assign mode    = pick_mode(en, byp_eff, lim_eff == '0);
    assign byp_run = run_q && byp_q;

    sclk_prescale #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .limit   (pre_eff),
        .cnt_d   (pcnt_d),
        .wrap    (wrap)
    );

    sclk_cycle #(.W(CYC_W)) u_cyc (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .step    (wrap),
        .limit   (lim_eff),
        .cnt_d   (ccnt_d)
    );

    sclk_wave #(.PRE_W(PRE_W), .CYC_W(CYC_W)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .pcnt_d  (pcnt_d),
        .ccnt_d  (ccnt_d),
        .pre_m1  (pre_eff),
        .high_m1 (high_eff),
        .wave_q  (wave_q),
        .rise_q  (rise_q),
        .fall_q  (fall_q)
    );

    assign sclk      = byp_run ? clk : wave_q;
    assign sclk_rise = byp_run | rise_q;
    assign sclk_fall = byp_run | fall_q;
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cfg_bypass,
    input logic sclk,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic byp_run
);
    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!byp_run && sclk_rise) |-> (sclk && !$past(sclk)));              // R6

    AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!byp_run && sclk_fall) |-> (!sclk && $past(sclk)));              // R6

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !byp_run |-> !(sclk_rise && sclk_fall));                          // R6

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (!sclk && !sclk_rise));                            // R9

    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        (en && !$past(en) && !cfg_bypass) |=> (sclk && sclk_rise));       // R2
endmodule

bind sclk_gen sclk_gen_chk u_sclk_gen_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .cfg_bypass (cfg_bypass),
    .sclk       (sclk),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .byp_run    (byp_run)
);

// File: tb/test_sclk_gen.sv
module test_sclk_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_W = 13;
    localparam int CYC_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             cfg_bypass = 1'b0;
    logic [PRE_W-1:0] cfg_pre_m1 = '0;
    logic [CYC_W-1:0] cfg_cyc_m1 = '0;
    logic [CYC_W-1:0] cfg_high_m1 = '0;
    logic [CYC_W-1:0] cfg_low_m1 = '0;
    logic             sclk, sclk_rise, sclk_fall;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_gen #(.PRE_W(PRE_W), .CYC_W(CYC_W)) i_sclk_gen (
        .clk, .rst, .en, .cfg_bypass, .cfg_pre_m1, .cfg_cyc_m1,
        .cfg_high_m1, .cfg_low_m1, .sclk, .sclk_rise, .sclk_fall
    );

    task automatic chk(input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %0b expected %0b",
                     cur_req, what, $time, act, exp);
        end
    endtask

    // Behavioural reference: time index within the period since start
    int m_run = 0, m_byp = 0, m_p = 1, m_n = 1, m_h = 1, m_t = 0;
    bit e_s = 0, e_r = 0, e_f = 0, e_prev = 0;

    initial begin
        forever begin
            @(posedge clk);
            if (rst || !en) begin
                e_r = 0;
                e_f = (!rst && e_prev);
                e_s = 0;
                e_prev = 0;
                m_run = 0;
                m_byp = 0;
            end else begin
                if (!m_run) begin
                    m_run = 1;
                    m_byp = cfg_bypass;
                    m_p = int'(cfg_pre_m1) + 1;
                    m_n = ((cfg_low_m1 < cfg_cyc_m1) ? int'(cfg_low_m1) : int'(cfg_cyc_m1)) + 1;
                    m_h = int'(cfg_high_m1) + 1;
                    m_t = 0;
                end else begin
                    m_t = (m_t + 1) % (m_p * m_n);
                end
                if (m_byp != 0) begin
                    e_s = 0; e_r = 1; e_f = 1; e_prev = 0;
                end else begin
                    if (m_n == 1) e_s = ((m_t % m_p) < (m_p + 1) / 2);
                    else          e_s = ((m_t / m_p) < m_h);
                    e_r = e_s && !e_prev;
                    e_f = !e_s && e_prev;
                    e_prev = e_s;
                end
            end
            #2;
            chk("sclk(clk high)", sclk, (m_run != 0 && m_byp != 0) ? 1'b1 : e_s);
            chk("rise", sclk_rise, e_r);
            chk("fall", sclk_fall, e_f);
            #5;
            chk("sclk(clk low)", sclk, (m_run != 0 && m_byp != 0) ? 1'b0 : e_s);
        end
    end

    task automatic run_seg(input string req, input bit byp, input int pre,
                           input int cyc, input int high, input int low,
                           input int cycles);
        @(negedge clk);
        cur_req = req;
        cfg_bypass  = byp;
        cfg_pre_m1  = PRE_W'(pre);
        cfg_cyc_m1  = CYC_W'(cyc);
        cfg_high_m1 = CYC_W'(high);
        cfg_low_m1  = CYC_W'(low);
        en = 1'b1;
        repeat (cycles) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("reset sclk", sclk, 1'b0);
        chk("reset rise", sclk_rise, 1'b0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("idle sclk R1", sclk, 1'b0);

        run_seg("R2/R3/R4/R6", 0, 2, 3, 1, 3, 60);
        run_seg("R3/R6 fastest", 0, 0, 1, 0, 1, 20);
        run_seg("R4 h=n", 0, 4, 4, 4, 4, 40);
        run_seg("R4 h>n", 0, 1, 2, 9, 2, 20);
        run_seg("R5 n=1", 0, 4, 0, 0, 0, 30);
        run_seg("R5 n=1 p=1", 0, 0, 0, 3, 0, 10);
        run_seg("R7 bypass", 1, 37, 5, 2, 5, 12);
        run_seg("R10 low<cyc", 0, 1, 7, 1, 3, 40);
        run_seg("R3 long prescale", 0, 99, 2, 1, 2, 700);
        run_seg("R9 stop in high", 0, 3, 3, 2, 3, 6);

        // R8: change configuration while running
        @(negedge clk);
        cur_req = "R8";
        cfg_bypass = 0; cfg_pre_m1 = 1; cfg_cyc_m1 = 3;
        cfg_high_m1 = 1; cfg_low_m1 = 3;
        en = 1'b1;
        repeat (5) @(negedge clk);
        cfg_bypass = 1; cfg_pre_m1 = 6; cfg_cyc_m1 = 1;
        cfg_high_m1 = 0; cfg_low_m1 = 0;
        repeat (30) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk("idle after R8 run", sclk, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule